// File: doc/BRIEF.md
# PLL Operating Mode Controller

This block is the supervisory state machine that sits beside a jitter-attenuating PLL. It stays in an initialization phase until a completion flag arrives. It then keeps the loop in one of four modes: free-run, lock acquisition, locked and holdover. Its inputs are a valid flag for each reference input, the index of the reference currently in use, and the lock and loss-of-lock indications from the loop. The analog loop, the phase detector and the lock measurement are outside the block and appear only as these flags.

When the reference in use drops out, the controller takes one of three paths. If another reference is valid, it issues a one-cycle switch request naming that reference and stays in acquisition. If none is valid and the holdover history is usable, it enters holdover. Otherwise it falls back to free-run. It also chooses the loop bandwidth. Fastlock can be forced or can follow loss-of-lock. A dedicated bandwidth governs the relock after leaving holdover when ramping is bypassed. Three shadow bandwidth words are copied into their active copies together by one update strobe.

Top module: `pll_mode_ctrl`

## Requirements
- R1: While initialization is pending (from reset until `init_done` is sampled high), `init_busy` is 1, `mode` is 00, `clk_en` is 0, `sw_req` is 0 and `bw_sel` is 00.
- R2: On the edge where `init_done` is sampled high, the controller leaves initialization. Its next mode is acquisition (01) if `in_valid[sel_idx]` is 1, and free-run (00) otherwise. `clk_en` is 1 from then on.
- R3: In free-run (00) or holdover (11), a valid selected input moves the mode to acquisition on the next edge with no switch request. If the selected input is invalid and some other input is valid, the mode moves to acquisition and a switch request is raised.
- R4: In acquisition, `lock_det` with a valid selected input moves the mode to locked (10) on the next edge.
- R5: A switch request is a one-cycle pulse on `sw_req`. It is registered, so it appears together with the mode change, and `sw_idx` holds the lowest-numbered valid input other than `sel_idx`.
- R6: If the selected input is invalid in acquisition or locked and no other input is valid, the next mode is holdover (11) when `hist_valid` is 1 and free-run (00) when it is 0.
- R7: A failure of the selected input takes priority over `lock_det` in the same cycle, so the mode never goes to locked on that edge.
- R8: In locked mode with a valid selected input, `lol` = 1 returns the mode to acquisition on the next edge.
- R9: `bw_sel` codes are 00 nominal, 01 fastlock and 10 holdover-exit. After initialization, `fl_force` = 1 gives 01 in every mode. Otherwise `fl_auto` = 1 with `lol` = 1 gives 01, and all other cases give 00. The value follows these inputs in the same cycle.
- R10: Leaving holdover for acquisition while `ramp_byp` = 1 selects 10 for the whole of that acquisition, ahead of auto fastlock but behind `fl_force`. It returns to the other rules once the mode leaves acquisition. With `ramp_byp` = 0 the holdover-exit code is never selected.
- R11: A `bw_upd` pulse copies all three shadow words into `act_nom`, `act_fast` and `act_hx` on the same edge. Without the pulse the active words hold, whatever the shadows do. After reset they are 0.
- R12: `bw_now` equals the active word picked by `bw_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| init_done | input | 1 | Initialization finished |
| in_valid | input | N_IN | Per-input qualified flags |
| sel_idx | input | SEL_W | Index of the input in use |
| lock_det | input | 1 | Phase lock reported |
| lol | input | 1 | Loss of lock reported |
| hist_valid | input | 1 | Holdover history usable |
| fl_auto | input | 1 | Fastlock follows loss-of-lock |
| fl_force | input | 1 | Fastlock forced |
| ramp_byp | input | 1 | Ramping bypassed, holdover-exit bandwidth allowed |
| bw_upd | input | 1 | Copy shadow bandwidths to active |
| sh_nom | input | BW_W | Nominal bandwidth shadow |
| sh_fast | input | BW_W | Fastlock bandwidth shadow |
| sh_hx | input | BW_W | Holdover-exit bandwidth shadow |
| init_busy | output | 1 | Initialization still pending |
| clk_en | output | 1 | Output clocks may run |
| mode | output | 2 | 00 free-run, 01 acquisition, 10 locked, 11 holdover |
| sw_req | output | 1 | One-cycle input switch request |
| sw_idx | output | SEL_W | Input to switch to |
| bw_sel | output | 2 | 00 nominal, 01 fastlock, 10 holdover-exit |
| act_nom | output | BW_W | Active nominal bandwidth |
| act_fast | output | BW_W | Active fastlock bandwidth |
| act_hx | output | BW_W | Active holdover-exit bandwidth |
| bw_now | output | BW_W | Active bandwidth now in use |

## Verification
The key collision is a lock report arriving in the same cycle that the selected input fails. The bench sets `lock_det` high and clears the selected valid flag before the same edge. It does this once with a spare input available, where it expects acquisition plus a switch request, and once with none available and no history, where it expects free-run. The mode must not show locked in either case. A second overlap is between the holdover-exit and fastlock choices during a relock. Auto fastlock with loss-of-lock is raised while the holdover-exit code is active, and the code must stay at holdover-exit until `fl_force` overrides it.

// File: rtl/pll_mode_pkg.sv
package pll_mode_pkg;

  typedef enum logic [1:0] {
    MD_FREE = 2'b00,
    MD_ACQ  = 2'b01,
    MD_LOCK = 2'b10,
    MD_HOLD = 2'b11
  } mode_t;

  typedef enum logic [1:0] {
    BW_NOM  = 2'b00,
    BW_FAST = 2'b01,
    BW_HX   = 2'b10
  } bw_sel_t;

  localparam int unsigned BW_KINDS = 3;

endpackage

// File: rtl/pll_alt_pick.sv
module pll_alt_pick #(
  parameter int unsigned N_IN  = 4,
  parameter int unsigned SEL_W = 2
) (
  input  logic [N_IN-1:0]  in_valid,
  input  logic [SEL_W-1:0] sel_idx,
  output logic             sel_ok,
  output logic             alt_found,
  output logic [SEL_W-1:0] alt_idx
);

  logic [N_IN-1:0] cand;

  // every input other than the one in use is a candidate when valid
  for (genvar g = 0; g < N_IN; g++) begin : g_cand
    assign cand[g] = in_valid[g] && (sel_idx != SEL_W'(g));
  end

  assign sel_ok    = (int'(sel_idx) < N_IN) ? in_valid[sel_idx] : 1'b0;
  assign alt_found = |cand;

  // lowest index wins
  always_comb begin
    alt_idx = '0;
    for (int i = N_IN - 1; i >= 0; i--) begin
      if (cand[i]) alt_idx = SEL_W'(i);
    end
  end

endmodule

// File: rtl/pll_mode_fsm.sv
module pll_mode_fsm
  import pll_mode_pkg::*;
#(
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_done,
  input  logic             sel_ok,
  input  logic             alt_found,
  input  logic [SEL_W-1:0] alt_idx,
  input  logic             lock_det,
  input  logic             lol,
  input  logic             hist_valid,
  input  logic             ramp_byp,
  input  logic             fl_force,
  input  logic             fl_auto,
  output logic             init_busy,
  output mode_t            mode,
  output logic             sw_req,
  output logic [SEL_W-1:0] sw_idx,
  output bw_sel_t          bw_sel
);

  logic             init_q, init_d;
  mode_t            mode_q, mode_d;
  logic             req_q, req_d;
  logic [SEL_W-1:0] idx_q;
  logic             idx_en;
  logic             hx_q, hx_d;

  // next-state logic
  always_comb begin
    init_d = init_q;
    mode_d = mode_q;
    req_d  = 1'b0;
    if (init_q) begin
      if (init_done) begin
        init_d = 1'b0;
        mode_d = sel_ok ? MD_ACQ : MD_FREE;
      end
    end else begin
      unique case (mode_q)
        MD_FREE, MD_HOLD: begin
          if (sel_ok) begin
            mode_d = MD_ACQ;
          end else if (alt_found) begin
            mode_d = MD_ACQ;
            req_d  = 1'b1;
          end
        end
        MD_ACQ, MD_LOCK: begin
          if (!sel_ok) begin
            if (alt_found) begin
              mode_d = MD_ACQ;
              req_d  = 1'b1;
            end else begin
              mode_d = hist_valid ? MD_HOLD : MD_FREE;
            end
          end else if (mode_q == MD_ACQ && lock_det) begin
            mode_d = MD_LOCK;
          end else if (mode_q == MD_LOCK && lol) begin
            mode_d = MD_ACQ;
          end
        end
        default: mode_d = MD_FREE;
      endcase
    end
  end

  assign idx_en = req_d;

  // holdover-exit window: opened on a bypassed-ramp exit, kept while in acquisition
  always_comb begin
    hx_d = 1'b0;
    if (!init_q && mode_d == MD_ACQ) begin
      hx_d = (mode_q == MD_HOLD && ramp_byp) || (mode_q == MD_ACQ && hx_q);
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q <= 1'b1;
      mode_q <= MD_FREE;
      req_q  <= 1'b0;
      hx_q   <= 1'b0;
    end else begin
      init_q <= init_d;
      mode_q <= mode_d;
      req_q  <= req_d;
      hx_q   <= hx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= alt_idx;
    end
  end

  // bandwidth choice
  always_comb begin
    if (init_q)                 bw_sel = BW_NOM;
    else if (fl_force)          bw_sel = BW_FAST;
    else if (hx_q)              bw_sel = BW_HX;
    else if (fl_auto && lol)    bw_sel = BW_FAST;
    else                        bw_sel = BW_NOM;
  end

  assign init_busy = init_q;
  assign mode      = mode_q;
  assign sw_req    = req_q;
  assign sw_idx    = idx_q;

endmodule

// File: rtl/pll_bw_bank.sv
module pll_bw_bank
  import pll_mode_pkg::*;
#(
  parameter int unsigned BW_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bw_upd,
  input  logic [BW_W-1:0] sh_nom,
  input  logic [BW_W-1:0] sh_fast,
  input  logic [BW_W-1:0] sh_hx,
  input  bw_sel_t         bw_sel,
  output logic [BW_W-1:0] act_nom,
  output logic [BW_W-1:0] act_fast,
  output logic [BW_W-1:0] act_hx,
  output logic [BW_W-1:0] bw_now
);

  logic [BW_W-1:0] shadow [BW_KINDS];
  logic [BW_W-1:0] active [BW_KINDS];

  assign shadow[0] = sh_nom;
  assign shadow[1] = sh_fast;
  assign shadow[2] = sh_hx;

  for (genvar k = 0; k < BW_KINDS; k++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        active[k] <= '0;
      end else if (bw_upd) begin
        active[k] <= shadow[k];
      end
    end
  end

  assign act_nom  = active[0];
  assign act_fast = active[1];
  assign act_hx   = active[2];

  always_comb begin
    unique case (bw_sel)
      BW_FAST: bw_now = active[1];
      BW_HX:   bw_now = active[2];
      default: bw_now = active[0];
    endcase
  end

endmodule

// File: rtl/pll_mode_ctrl.sv
module pll_mode_ctrl
  import pll_mode_pkg::*;
#(
  parameter int unsigned N_IN  = 4,
  parameter int unsigned BW_W  = 16,
  localparam int unsigned SEL_W = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_done,
  input  logic [N_IN-1:0]  in_valid,
  input  logic [SEL_W-1:0] sel_idx,
  input  logic             lock_det,
  input  logic             lol,
  input  logic             hist_valid,
  input  logic             fl_auto,
  input  logic             fl_force,
  input  logic             ramp_byp,
  input  logic             bw_upd,
  input  logic [BW_W-1:0]  sh_nom,
  input  logic [BW_W-1:0]  sh_fast,
  input  logic [BW_W-1:0]  sh_hx,
  output logic             init_busy,
  output logic             clk_en,
  output logic [1:0]       mode,
  output logic             sw_req,
  output logic [SEL_W-1:0] sw_idx,
  output logic [1:0]       bw_sel,
  output logic [BW_W-1:0]  act_nom,
  output logic [BW_W-1:0]  act_fast,
  output logic [BW_W-1:0]  act_hx,
  output logic [BW_W-1:0]  bw_now
);

  logic [1:0]       rst_pipe;
  logic             rst_sync_n;
  logic             sel_ok;
  logic             alt_found;
  logic [SEL_W-1:0] alt_idx;
  mode_t            mode_i;
  bw_sel_t          bw_sel_i;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  pll_alt_pick #(.N_IN(N_IN), .SEL_W(SEL_W)) i_pick (
    .in_valid  (in_valid),
    .sel_idx   (sel_idx),
    .sel_ok    (sel_ok),
    .alt_found (alt_found),
    .alt_idx   (alt_idx)
  );

  pll_mode_fsm #(.SEL_W(SEL_W)) i_fsm (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .init_done  (init_done),
    .sel_ok     (sel_ok),
    .alt_found  (alt_found),
    .alt_idx    (alt_idx),
    .lock_det   (lock_det),
    .lol        (lol),
    .hist_valid (hist_valid),
    .ramp_byp   (ramp_byp),
    .fl_force   (fl_force),
    .fl_auto    (fl_auto),
    .init_busy  (init_busy),
    .mode       (mode_i),
    .sw_req     (sw_req),
    .sw_idx     (sw_idx),
    .bw_sel     (bw_sel_i)
  );

  pll_bw_bank #(.BW_W(BW_W)) i_bank (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .bw_upd   (bw_upd),
    .sh_nom   (sh_nom),
    .sh_fast  (sh_fast),
    .sh_hx    (sh_hx),
    .bw_sel   (bw_sel_i),
    .act_nom  (act_nom),
    .act_fast (act_fast),
    .act_hx   (act_hx),
    .bw_now   (bw_now)
  );

  assign mode   = mode_i;
  assign bw_sel = bw_sel_i;
  assign clk_en = !init_busy;

endmodule

// File: rtl/pll_mode_ctrl_chk.sv
module pll_mode_ctrl_chk #(
  parameter int unsigned N_IN  = 4,
  parameter int unsigned BW_W  = 16,
  parameter int unsigned SEL_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_IN-1:0]  in_valid,
  input logic [SEL_W-1:0] sel_idx,
  input logic             lock_det,
  input logic             lol,
  input logic             hist_valid,
  input logic             fl_force,
  input logic             bw_upd,
  input logic [BW_W-1:0]  sh_nom,
  input logic [BW_W-1:0]  sh_fast,
  input logic [BW_W-1:0]  sh_hx,
  input logic             init_busy,
  input logic             clk_en,
  input logic [1:0]       mode,
  input logic             sw_req,
  input logic [1:0]       bw_sel,
  input logic [BW_W-1:0]  act_nom,
  input logic [BW_W-1:0]  act_fast,
  input logic [BW_W-1:0]  act_hx
);

  logic            cur_ok;
  logic [N_IN-1:0] others;
  assign cur_ok = in_valid[sel_idx];
  assign others = in_valid & ~(N_IN'(1) << sel_idx);

  // R1
  init_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_busy |-> (!clk_en && mode == 2'b00 && !sw_req && bw_sel == 2'b00));

  // R7
  fail_beats_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_busy && mode == 2'b01 && !cur_ok && lock_det) |=> mode != 2'b10);

  // R6
  hold_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_busy && mode == 2'b10 && !cur_ok && others == '0 && hist_valid) |=> mode == 2'b11);

  // R8
  lol_relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_busy && mode == 2'b10 && cur_ok && lol) |=> mode == 2'b01);

  // R5
  req_in_acq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_req |-> (mode == 2'b01 && !init_busy));

  // R9
  force_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_busy && fl_force) |-> bw_sel == 2'b01);

  // R11
  upd_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bw_upd |=> (act_nom == $past(sh_nom) && act_fast == $past(sh_fast) && act_hx == $past(sh_hx)));

  // R11
  hold_words_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bw_upd |=> ($stable(act_nom) && $stable(act_fast) && $stable(act_hx)));

endmodule

bind pll_mode_ctrl pll_mode_ctrl_chk #(.N_IN(N_IN), .BW_W(BW_W), .SEL_W(SEL_W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .in_valid   (in_valid),
  .sel_idx    (sel_idx),
  .lock_det   (lock_det),
  .lol        (lol),
  .hist_valid (hist_valid),
  .fl_force   (fl_force),
  .bw_upd     (bw_upd),
  .sh_nom     (sh_nom),
  .sh_fast    (sh_fast),
  .sh_hx      (sh_hx),
  .init_busy  (init_busy),
  .clk_en     (clk_en),
  .mode       (mode),
  .sw_req     (sw_req),
  .bw_sel     (bw_sel),
  .act_nom    (act_nom),
  .act_fast   (act_fast),
  .act_hx     (act_hx)
);

// File: tb/test_pll_mode_ctrl.sv
module test_pll_mode_ctrl;

  localparam int CLK_PER = 10;
  localparam int N_IN    = 4;
  localparam int BW_W    = 16;
  localparam int SEL_W   = 2;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             init_done;
  logic [N_IN-1:0]  in_valid;
  logic [SEL_W-1:0] sel_idx;
  logic             lock_det, lol, hist_valid, fl_auto, fl_force, ramp_byp, bw_upd;
  logic [BW_W-1:0]  sh_nom, sh_fast, sh_hx;
  logic             init_busy, clk_en, sw_req;
  logic [1:0]       mode, bw_sel;
  logic [SEL_W-1:0] sw_idx;
  logic [BW_W-1:0]  act_nom, act_fast, act_hx, bw_now;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #(CLK_PER/2) clk = ~clk;

  pll_mode_ctrl #(.N_IN(N_IN), .BW_W(BW_W)) i_pll_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .init_done(init_done), .in_valid(in_valid),
    .sel_idx(sel_idx), .lock_det(lock_det), .lol(lol), .hist_valid(hist_valid),
    .fl_auto(fl_auto), .fl_force(fl_force), .ramp_byp(ramp_byp), .bw_upd(bw_upd),
    .sh_nom(sh_nom), .sh_fast(sh_fast), .sh_hx(sh_hx), .init_busy(init_busy),
    .clk_en(clk_en), .mode(mode), .sw_req(sw_req), .sw_idx(sw_idx),
    .bw_sel(bw_sel), .act_nom(act_nom), .act_fast(act_fast), .act_hx(act_hx),
    .bw_now(bw_now)
  );

  task automatic chk(input int act, input int exp, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic cyc(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; init_done = 0; in_valid = '0; sel_idx = '0; lock_det = 0;
    lol = 0; hist_valid = 0; fl_auto = 0; fl_force = 0; ramp_byp = 0; bw_upd = 0;
    sh_nom = '0; sh_fast = '0; sh_hx = '0;
    cyc(2);
    rst_n = 1'b1;
    cyc(3);
  endtask

  // from reset to locked on input s
  task automatic go_locked(input int s);
    do_reset();
    in_valid = 4'b1111; sel_idx = SEL_W'(s); init_done = 1;
    cyc();
    lock_det = 1;
    cyc();
    lock_det = 0;
  endtask

  task automatic t_init();
    do_reset();
    in_valid = 4'b1111; fl_force = 1; lol = 1; fl_auto = 1;
    cyc(3);
    chk(init_busy, 1, "R1 busy");
    chk(mode, 0, "R1 mode");
    chk(clk_en, 0, "R1 clk_en");
    chk(sw_req, 0, "R1 sw_req");
    chk(bw_sel, 0, "R1 bw_sel");
    init_done = 1; fl_force = 0; lol = 0; fl_auto = 0;
    cyc();
    chk(mode, 1, "R2 exit to acq");
    chk(clk_en, 1, "R2 clk_en");
    do_reset();
    in_valid = 4'b0100; sel_idx = 0; init_done = 1;
    cyc();
    chk(mode, 0, "R2 exit to free");
    chk(sw_req, 0, "R2 no req");
  endtask

  task automatic t_free_exit();
    // continues from free-run, sel 0 invalid, input 2 valid
    in_valid = 4'b1100;
    cyc();
    chk(mode, 1, "R3 free to acq with switch");
    chk(sw_req, 1, "R5 req pulse");
    chk(sw_idx, 2, "R5 lowest other valid");
    sel_idx = 2;
    cyc();
    chk(sw_req, 0, "R5 req one cycle");
    lock_det = 1;
    cyc();
    chk(mode, 2, "R4 acq to locked");
    lock_det = 0;
  endtask

  task automatic t_lol();
    go_locked(1);
    chk(mode, 2, "R4 locked");
    fl_auto = 1; lol = 1;
    #1;
    chk(bw_sel, 1, "R9 auto fastlock on lol");
    chk(bw_now, 0, "R12 bw_now fast after reset");
    cyc();
    chk(mode, 1, "R8 lol to acq");
    lol = 0;
    #1;
    chk(bw_sel, 0, "R9 fastlock dropped");
    fl_auto = 0;
  endtask

  task automatic t_fail_switch();
    go_locked(0);
    in_valid = 4'b1010;
    cyc();
    chk(mode, 1, "R5 fail to acq");
    chk(sw_req, 1, "R5 req on fail");
    chk(sw_idx, 1, "R5 idx on fail");
  endtask

  task automatic t_fail_noalt();
    go_locked(3);
    hist_valid = 1; in_valid = 4'b0000;
    cyc();
    chk(mode, 3, "R6 to holdover");
    chk(sw_req, 0, "R6 no req");
    go_locked(3);
    hist_valid = 0; in_valid = 4'b0000;
    cyc();
    chk(mode, 0, "R6 to free-run");
  endtask

  task automatic t_priority();
    do_reset();
    in_valid = 4'b1111; sel_idx = 0; init_done = 1;
    cyc();
    lock_det = 1; in_valid = 4'b1000;
    cyc();
    chk(mode, 1, "R7 fail beats lock, switch");
    chk(sw_req, 1, "R7 req");
    chk(sw_idx, 3, "R7 idx");
    in_valid = 4'b0000; hist_valid = 0;
    cyc();
    chk(mode, 0, "R7 fail beats lock, free");
    lock_det = 0;
  endtask

  task automatic t_hold_exit();
    go_locked(2);
    hist_valid = 1; in_valid = 4'b0000;
    cyc();
    chk(mode, 3, "R6 hold");
    ramp_byp = 1; in_valid = 4'b0100;
    cyc();
    chk(mode, 1, "R3 hold to acq");
    chk(sw_req, 0, "R3 no req when sel valid");
    chk(bw_sel, 2, "R10 hx bw");
    fl_auto = 1; lol = 1;
    #1;
    chk(bw_sel, 2, "R10 hx beats auto fastlock");
    fl_force = 1;
    #1;
    chk(bw_sel, 1, "R10 force beats hx");
    fl_force = 0; fl_auto = 0; lol = 0; lock_det = 1;
    cyc();
    lock_det = 0;
    chk(mode, 2, "R4 relocked");
    chk(bw_sel, 0, "R10 hx ends");
    // ramp not bypassed
    in_valid = 4'b0000; ramp_byp = 0;
    cyc();
    in_valid = 4'b0010;
    cyc();
    chk(mode, 1, "R3 hold to acq with switch");
    chk(sw_req, 1, "R3 req from hold");
    chk(bw_sel, 0, "R10 no hx when ramp used");
  endtask

  task automatic t_bw();
    do_reset();
    chk(act_nom, 0, "R11 reset nom");
    sh_nom = 16'h1111; sh_fast = 16'h2222; sh_hx = 16'h3333;
    cyc(2);
    chk(act_fast, 0, "R11 held without upd");
    bw_upd = 1;
    cyc();
    bw_upd = 0;
    chk(act_nom, 16'h1111, "R11 nom copied");
    chk(act_fast, 16'h2222, "R11 fast copied");
    chk(act_hx, 16'h3333, "R11 hx copied");
    sh_nom = 16'hAAAA; sh_fast = 16'hBBBB; sh_hx = 16'hCCCC;
    cyc(2);
    chk(act_hx, 16'h3333, "R11 hx held");
    in_valid = 4'b0001; init_done = 1;
    cyc();
    chk(bw_now, 16'h1111, "R12 nominal word");
    fl_force = 1;
    #1;
    chk(bw_now, 16'h2222, "R12 fast word");
    fl_force = 0;
  endtask

  initial begin
    t_init();
    t_free_exit();
    t_lol();
    t_fail_switch();
    t_fail_noalt();
    t_priority();
    t_hold_exit();
    t_bw();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PER * 100000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule